// File: doc/BRIEF.md
# Shift Register with J/K-bar First-Stage Entry

This block is a synchronous register of `WIDTH` stages with two operating modes, chosen by a single mode input. In load mode, every rising clock edge copies a parallel data word into the stages. In shift mode, every rising clock edge moves the contents one position from stage 0 toward the highest stage.

In shift mode, the new value of stage 0 comes from a J input and an inverted-K input. This pair can set, clear, toggle or hold the first stage while the rest of the register shifts. Tying J and K-bar together turns the pair into an ordinary serial data input.

An active-low asynchronous reset clears all stages. A complemented copy of the highest stage is provided as an extra output. The block is used as a serial-to-parallel or parallel-to-serial converter, and as a small counter or sequence generator.

Top module: `jk_shift_register`

## Requirements
- R1: While `rst_n` is 0, `stage_q` is all zeros and `last_n` is 1, whatever the clock, mode and data inputs do.
- R2: With `shift_en` = 1, a rising edge moves each stage i (i >= 1) to the value stage i-1 held before the edge.
- R3: With `shift_en` = 0, a rising edge loads `par_d[i]` into stage i for every i.
- R4: In shift mode with `j_in` = 1 and `kb_in` = 1, stage 0 becomes 1 after the edge.
- R5: In shift mode with `j_in` = 0 and `kb_in` = 0, stage 0 becomes 0 after the edge.
- R6: In shift mode with `j_in` = 1 and `kb_in` = 0, stage 0 becomes the inverse of its previous value.
- R7: In shift mode with `j_in` = 0 and `kb_in` = 1, stage 0 keeps its previous value.
- R8: `last_n` always equals the complement of stage `WIDTH-1`.
- R9: After `rst_n` returns to 1, the next rising edge is the first one that acts, and it uses the mode and data present at that edge.
- R10: In load mode, `j_in` and `kb_in` have no effect. In shift mode, `par_d` has no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low asynchronous clear |
| shift_en | input | 1 | 1 = shift toward the high stage, 0 = parallel load |
| j_in | input | 1 | J input of the first stage |
| kb_in | input | 1 | Inverted-K input of the first stage |
| par_d | input | WIDTH | Parallel load data; bit i goes to stage i |
| stage_q | output | WIDTH | Stage contents; bit i is stage i |
| last_n | output | 1 | Complement of stage WIDTH-1 |

## Verification
The assertions check every active clock cycle:
- the one-place move of the upper stages during shifting;
- the word copy during loading;
- all four J/K-bar outcomes on stage 0;
- the complement relation of `last_n`.

Some behaviours are shown only by the bench scenarios:
- the asynchronous clear taking effect between clock edges;
- the first edge after reset release acting;
- the inputs of the inactive mode being ignored.

The bench also compares long random mode and data sequences, with resets dropped in mid-sequence, against an independent model.

// File: rtl/jks_pkg.sv
package jks_pkg;
  typedef enum logic {MODE_LOAD = 1'b0, MODE_SHIFT = 1'b1} mode_e;

  // Next value of the first stage from J, K-bar and its current value.
  function automatic logic first_next(input logic j, input logic kb, input logic q);
    return (j & ~q) | (kb & q);
  endfunction
endpackage

// File: rtl/jks_entry.sv
module jks_entry
  import jks_pkg::*;
(
  input  logic j_in,
  input  logic kb_in,
  input  logic q0,
  output logic d0
);
  assign d0 = first_next(j_in, kb_in, q0);
endmodule

// File: rtl/jks_chain.sv
module jks_chain
  import jks_pkg::*;
#(
  parameter int WIDTH = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  mode_e            mode,
  input  logic             entry_d,
  input  logic [WIDTH-1:0] par_d,
  output logic [WIDTH-1:0] q,
  output logic             top_n
);
  localparam int TOP = WIDTH - 1;

  logic [WIDTH-1:0] nxt;

  for (genvar i = 0; i < WIDTH; i++) begin : g_stage
    if (i == 0) begin : g_head
      assign nxt[i] = (mode == MODE_LOAD) ? par_d[i] : entry_d;
    end else begin : g_body
      assign nxt[i] = (mode == MODE_LOAD) ? par_d[i] : q[i-1];
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) q[i] <= 1'b0;
      else        q[i] <= nxt[i];
    end
  end

  assign top_n = ~q[TOP];
endmodule

// File: rtl/jk_shift_register.sv
module jk_shift_register
  import jks_pkg::*;
#(
  parameter int WIDTH = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             shift_en,
  input  logic             j_in,
  input  logic             kb_in,
  input  logic [WIDTH-1:0] par_d,
  output logic [WIDTH-1:0] stage_q,
  output logic             last_n
);
  localparam int TOP = WIDTH - 1;

  mode_e mode;
  logic  entry_d;
  // Named events for the assertions
  logic  shift_evt, load_evt;
  logic  set_evt, clr_evt, tog_evt, hold_evt;

  assign mode      = shift_en ? MODE_SHIFT : MODE_LOAD;
  assign shift_evt = (mode == MODE_SHIFT);
  assign load_evt  = (mode == MODE_LOAD);
  assign set_evt   = shift_evt &  j_in &  kb_in;
  assign clr_evt   = shift_evt & ~j_in & ~kb_in;
  assign tog_evt   = shift_evt &  j_in & ~kb_in;
  assign hold_evt  = shift_evt & ~j_in &  kb_in;

  jks_entry u_entry (
    .j_in  (j_in),
    .kb_in (kb_in),
    .q0    (stage_q[0]),
    .d0    (entry_d)
  );

  jks_chain #(.WIDTH(WIDTH)) u_chain (
    .clk     (clk),
    .rst_n   (rst_n),
    .mode    (mode),
    .entry_d (entry_d),
    .par_d   (par_d),
    .q       (stage_q),
    .top_n   (last_n)
  );

  if (WIDTH >= 2) begin : g_shift_chk
    assert_shift_R2: assert property (@(posedge clk) disable iff (!rst_n)
      shift_evt |=> stage_q[TOP:1] == $past(stage_q[TOP-1:0]));
  end

  assert_load_R3: assert property (@(posedge clk) disable iff (!rst_n)
    load_evt |=> stage_q == $past(par_d));
  assert_set_R4: assert property (@(posedge clk) disable iff (!rst_n)
    set_evt |=> stage_q[0] == 1'b1);
  assert_clear_R5: assert property (@(posedge clk) disable iff (!rst_n)
    clr_evt |=> stage_q[0] == 1'b0);
  assert_toggle_R6: assert property (@(posedge clk) disable iff (!rst_n)
    tog_evt |=> stage_q[0] != $past(stage_q[0]));
  assert_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    hold_evt |=> $stable(stage_q[0]));
  assert_complement_R8: assert property (@(posedge clk) disable iff (!rst_n)
    last_n != stage_q[TOP]);
endmodule

// File: tb/sim_jk_shift_register.sv
`timescale 1ns/1ps
module sim_jk_shift_register;
  localparam int W = 4;
  localparam int MAXCYC = 100000;

  logic         clk = 1'b0;
  logic         rst_n = 1'b1;
  logic         shift_en = 1'b0, j_in = 1'b0, kb_in = 1'b0;
  logic [W-1:0] par_d = '0;
  logic [W-1:0] stage_q;
  logic         last_n;

  int checks = 0, errors = 0, cycles = 0;
  logic [W-1:0] model = '0;
  logic [W-1:0] exp_q[$];
  string        exp_tag[$];

  always #4 clk = ~clk;   // 125 MHz

  jk_shift_register #(.WIDTH(W)) u0 (
    .clk(clk), .rst_n(rst_n), .shift_en(shift_en), .j_in(j_in), .kb_in(kb_in),
    .par_d(par_d), .stage_q(stage_q), .last_n(last_n)
  );

  task automatic check(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %b expected %b", tag, act, exp);
    end
  endtask

  // Driver: one clock step. Also releases reset at the same point (R9).
  task automatic step(input logic sh, input logic j, input logic kb,
                      input logic [W-1:0] d, input string tag);
    logic f;
    @(negedge clk);
    rst_n = 1'b1;
    shift_en = sh; j_in = j; kb_in = kb; par_d = d;
    if (!sh) model = d;
    else begin
      case ({j, kb})
        2'b11: f = 1'b1;
        2'b00: f = 1'b0;
        2'b10: f = !model[0];
        default: f = model[0];
      endcase
      model = {model[W-2:0], f};
    end
    exp_q.push_back(model);
    exp_tag.push_back(tag);
  endtask

  // Asynchronous reset away from the edge, held for a few cycles
  task automatic apply_reset(input logic [W-1:0] junk);
    @(negedge clk);
    #1;
    rst_n = 1'b0;
    shift_en = junk[0]; j_in = junk[1]; kb_in = junk[2]; par_d = ~junk;
    #1;
    check("R1 stages clear", stage_q, '0);
    check("R1 last_n high", {{(W-1){1'b0}}, last_n}, 1);
    model = '0;
    repeat (2) @(posedge clk);
    #1;
    check("R1 clear held over edges", stage_q, '0);
  endtask

  // Monitor: compares after each active edge
  always @(posedge clk) begin
    cycles++;
    #2;
    if (exp_q.size() > 0) begin
      logic [W-1:0] e;
      string t;
      e = exp_q.pop_front();
      t = exp_tag.pop_front();
      check(t, stage_q, e);
      check("R8 last_n", {{(W-1){1'b0}}, last_n}, {{(W-1){1'b0}}, ~e[W-1]});
    end
  end

  initial begin
    wait (cycles > MAXCYC);
    errors++;
    $display("FAIL watchdog: actual %0d cycles expected < %0d", cycles, MAXCYC);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    apply_reset(4'b0111);
    step(0, 0, 0, 4'b1010, "R9 first edge after release loads");
    step(0, 1, 1, 4'b0110, "R3 parallel load");
    step(0, 1, 0, 4'b0110, "R10 J/K-bar ignored while loading");
    step(1, 1, 1, 4'b1111, "R4 set first stage");
    step(1, 0, 0, 4'b1111, "R5 clear first stage");
    step(1, 1, 0, 4'b0000, "R6 toggle first stage");
    step(1, 1, 0, 4'b1010, "R6 toggle again");
    step(1, 0, 1, 4'b0101, "R7 hold first stage");
    step(1, 0, 1, 4'b1111, "R10 par_d ignored while shifting");
    step(1, 1, 1, 4'b0000, "R2 D-style serial 1");
    step(1, 0, 0, 4'b0000, "R2 D-style serial 0");
    step(1, 1, 1, 4'b0000, "R2 D-style serial 1");
    step(1, 1, 1, 4'b0000, "R2 shift through last stage");
    apply_reset(4'b1001);
    step(1, 1, 1, 4'b0000, "R9 first edge after release shifts");
    for (int n = 0; n < 400; n++) begin
      logic [3:0] r;
      r = 4'($urandom);
      if (n % 97 == 50) apply_reset(4'($urandom));
      step(r[0], r[1], r[2], W'($urandom), r[0] ? "R2 random shift" : "R3 random load");
    end
    @(negedge clk);
    @(negedge clk);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule